// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Register

This block is the status word of an I2C controller. A separate bus engine reports protocol events as one-cycle strobes: a byte received, a byte sent, a missed acknowledge, an address match, a STOP seen, lost arbitration. The block keeps each event as a sticky flag at a fixed bit of a 32-bit word that software reads. Software clears a flag by writing a 1 to its bit. A live bus-busy bit is also shown; it is set only for traffic the controller is not part of.

Six of the flags each have an enable input that comes from the controller's separate control register. Each enabled flag drives a single registered interrupt line. The general-call indication does not drive the interrupt. It is cleared together with the slave-address flag.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset every flag reads 0 and `irq_o` is 0.
- R2: Bits 31 to 11 and bits 2 to 0 of `reg_rdata_o` always read 0. Writes to those bits have no effect.
- R3: Bit 10 (bus error) sets on the clock edge that samples `mst_tx_noack_i` or `slv_rx_nak_i` high.
- R4: Bit 9 (slave address) sets on an edge where `addr_hit_i` is high and `hit_own_i` or `hit_gc_i` is high. A strobe with neither match leaves it unchanged.
- R5: Bit 8 (general call) sets on an edge where `addr_hit_i` and `hit_gc_i` are both high. Writing 1 to bit 9 clears it. Writing 1 to bit 8 alone has no effect.
- R6: Bit 7 (receive full) sets on `rx_byte_i`. Bit 6 (transmit empty) sets on `tx_byte_i`.
- R7: Bit 5 (arbitration lost) sets on `arb_lost_i`.
- R8: Bit 4 (slave stop) sets on `stop_seen_i` only while `slave_mode_i` is 1. A STOP seen with `slave_mode_i` at 0 leaves it unchanged.
- R9: Bit 3 reads `bus_busy_i AND NOT unit_owns_bus_i` in the same cycle, without a register.
- R10: When `reg_we_i` is high, a 1 in `reg_wdata_i` clears the flag at bits 10, 9, 7, 6, 5 or 4 on that edge. A 0 leaves the flag unchanged.
- R11: If a flag's set event and a write-1 clear of that flag fall on the same edge, the flag ends at 1.
- R12: `irq_en_i` bits 0..5 enable, in order, bits 4, 5, 6, 7, 9 and 10. `irq_o` is a register. On each edge it loads the OR of (flag AND enable) taken from the flag values and enables present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the status word |
| reg_wdata_i | input | 32 | Write data; a 1 clears the matching flag |
| reg_rdata_o | output | 32 | Status word |
| mst_tx_noack_i | input | 1 | Strobe: no ACK after a byte sent as master |
| slv_rx_nak_i | input | 1 | Strobe: NAK sent as slave receiver |
| addr_hit_i | input | 1 | Strobe: address phase finished |
| hit_own_i | input | 1 | Address equals the own slave address |
| hit_gc_i | input | 1 | Address equals the general-call address |
| rx_byte_i | input | 1 | Strobe: byte received into the data buffer |
| tx_byte_i | input | 1 | Strobe: byte sending finished |
| arb_lost_i | input | 1 | Strobe: arbitration lost |
| stop_seen_i | input | 1 | Strobe: STOP condition seen |
| slave_mode_i | input | 1 | Unit is in slave receive or transmit |
| bus_busy_i | input | 1 | Bus is busy (level) |
| unit_owns_bus_i | input | 1 | Unit takes part in the transfer (level) |
| irq_en_i | input | 6 | Interrupt enables, mapping in R12 |
| irq_o | output | 1 | Registered interrupt |

## Verification
A strobe or write that is sampled at edge N changes the status word right after edge N. `irq_o` follows one edge later, because it is loaded from the flags as they stood before edge N+1. Bit 3 follows its inputs in the same cycle. For every step, the driver queues three expected items: the live bit, due in the current cycle; the full word excluding bit 3, due one cycle later; and the interrupt level, due one cycle later. The driver computes the interrupt level from the flag model as it stood before that step. The monitor samples on the falling edge and compares only the items whose due cycle has arrived.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W    = 32;
  localparam int NUM_W1C   = 6;
  localparam int BIT_BERR  = 10;
  localparam int BIT_SAD   = 9;
  localparam int BIT_GC    = 8;
  localparam int BIT_RXF   = 7;
  localparam int BIT_TXE   = 6;
  localparam int BIT_ARB   = 5;
  localparam int BIT_SSTOP = 4;
  localparam int BIT_BUSY  = 3;

  // enable index -> status bit
  function automatic int w1c_pos(input int idx);
    case (idx)
      0:       return BIT_SSTOP;
      1:       return BIT_ARB;
      2:       return BIT_TXE;
      3:       return BIT_RXF;
      4:       return BIT_SAD;
      default: return BIT_BERR;
    endcase
  endfunction
endpackage

// File: rtl/i2c_stat_flag.sv
module i2c_stat_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(flags_i & en_i);
  end
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
  import i2c_stat_pkg::*;
#(
  parameter int DATA_W = STAT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               mst_tx_noack_i,
  input  logic               slv_rx_nak_i,
  input  logic               addr_hit_i,
  input  logic               hit_own_i,
  input  logic               hit_gc_i,
  input  logic               rx_byte_i,
  input  logic               tx_byte_i,
  input  logic               arb_lost_i,
  input  logic               stop_seen_i,
  input  logic               slave_mode_i,
  input  logic               bus_busy_i,
  input  logic               unit_owns_bus_i,
  input  logic [NUM_W1C-1:0] irq_en_i,
  output logic               irq_o
);
  logic [NUM_W1C-1:0] set_vec, flag_vec;
  logic [DATA_W-1:0]  clr_mask;
  logic               gc_q;
  logic               unused_wdata;

  assign clr_mask     = reg_we_i ? reg_wdata_i : '0;
  assign unused_wdata = ^reg_wdata_i;

  assign set_vec[0] = stop_seen_i & slave_mode_i;
  assign set_vec[1] = arb_lost_i;
  assign set_vec[2] = tx_byte_i;
  assign set_vec[3] = rx_byte_i;
  assign set_vec[4] = addr_hit_i & (hit_own_i | hit_gc_i);
  assign set_vec[5] = mst_tx_noack_i | slv_rx_nak_i;

  for (genvar i = 0; i < NUM_W1C; i++) begin : g_flag
    localparam int POS = w1c_pos(i);
    i2c_stat_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[i]),
      .clr_i  (clr_mask[POS]),
      .flag_o (flag_vec[i])
    );
  end

  // general call follows the slave-address clear
  i2c_stat_flag u_gc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (addr_hit_i & hit_gc_i),
    .clr_i  (clr_mask[BIT_SAD]),
    .flag_o (gc_q)
  );

  i2c_stat_irq #(.N(NUM_W1C)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flag_vec),
    .en_i    (irq_en_i),
    .irq_o   (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_W1C; i++) reg_rdata_o[w1c_pos(i)] = flag_vec[i];
    reg_rdata_o[BIT_GC]   = gc_q;
    reg_rdata_o[BIT_BUSY] = bus_busy_i & ~unit_owns_bus_i;
  end
endmodule

// File: rtl/i2c_stat_reg_chk.sv
module i2c_stat_reg_chk
  import i2c_stat_pkg::*;
#(
  parameter int DATA_W = STAT_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic               mst_tx_noack_i,
  input logic               slv_rx_nak_i,
  input logic               addr_hit_i,
  input logic               hit_own_i,
  input logic               hit_gc_i,
  input logic               rx_byte_i,
  input logic               tx_byte_i,
  input logic               arb_lost_i,
  input logic               stop_seen_i,
  input logic               slave_mode_i,
  input logic               bus_busy_i,
  input logic               unit_owns_bus_i,
  input logic [NUM_W1C-1:0] irq_en_i,
  input logic               irq_o
);
  logic [NUM_W1C-1:0] flagv;
  logic               unused_chk;
  assign flagv = {reg_rdata_o[BIT_BERR], reg_rdata_o[BIT_SAD], reg_rdata_o[BIT_RXF],
                  reg_rdata_o[BIT_TXE], reg_rdata_o[BIT_ARB], reg_rdata_o[BIT_SSTOP]};
  assign unused_chk = ^reg_wdata_i;

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (flagv == '0 && !reg_rdata_o[BIT_GC] && !irq_o));

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DATA_W-1:11] == '0 && reg_rdata_o[2:0] == '0);

  p_berr_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_tx_noack_i || slv_rx_nak_i) |=> reg_rdata_o[BIT_BERR]);

  p_sad_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_hit_i && (hit_own_i || hit_gc_i)) |=> reg_rdata_o[BIT_SAD]);

  p_gc_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_hit_i && hit_gc_i) |=> reg_rdata_o[BIT_GC]);

  p_gc_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[BIT_SAD] && !(addr_hit_i && hit_gc_i)) |=> !reg_rdata_o[BIT_GC]);

  p_rxf_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_byte_i |=> reg_rdata_o[BIT_RXF]);

  p_txe_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_byte_i |=> reg_rdata_o[BIT_TXE]);

  p_arb_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_i |=> reg_rdata_o[BIT_ARB]);

  p_stop_master_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_seen_i && !slave_mode_i && !reg_rdata_o[BIT_SSTOP]) |=> !reg_rdata_o[BIT_SSTOP]);

  p_busy_live_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[BIT_BUSY] == (bus_busy_i && !unit_owns_bus_i));

  p_w1c_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[BIT_BERR] && !mst_tx_noack_i && !slv_rx_nak_i)
      |=> !reg_rdata_o[BIT_BERR]);

  p_w0_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[BIT_RXF] && !(reg_we_i && reg_wdata_i[BIT_RXF])) |=> reg_rdata_o[BIT_RXF]);

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_byte_i && reg_we_i && reg_wdata_i[BIT_TXE]) |=> reg_rdata_o[BIT_TXE]);

  p_irq_reg_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == |($past(flagv) & $past(irq_en_i))));
endmodule

bind i2c_stat_reg i2c_stat_reg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/i2c_stat_reg_bench.sv
module i2c_stat_reg_bench;
  typedef struct {
    logic        we;
    logic [31:0] wdata;
    logic noack, nak, ahit, own, gc, rxb, txb, arb, stop, slave, busy, owns;
    logic [5:0]  en;
  } stim_t;

  typedef struct {
    int          due;
    bit          is_irq;
    logic [31:0] mask;
    logic [31:0] exp;
    logic        exp_irq;
    string       tag;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  stim_t       st, drv;
  item_t       q[$];
  logic [31:0] model;
  int          cyc = 0, n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  i2c_stat_reg u_i2c_stat_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(drv.we), .reg_wdata_i(drv.wdata),
    .reg_rdata_o(rdata), .mst_tx_noack_i(drv.noack), .slv_rx_nak_i(drv.nak),
    .addr_hit_i(drv.ahit), .hit_own_i(drv.own), .hit_gc_i(drv.gc),
    .rx_byte_i(drv.rxb), .tx_byte_i(drv.txb), .arb_lost_i(drv.arb),
    .stop_seen_i(drv.stop), .slave_mode_i(drv.slave), .bus_busy_i(drv.busy),
    .unit_owns_bus_i(drv.owns), .irq_en_i(drv.en), .irq_o(irq));

  function automatic logic [5:0] pick(input logic [31:0] w);
    return {w[10], w[9], w[7], w[6], w[5], w[4]};
  endfunction

  task automatic tick(input string tag);
    logic [31:0] set_w, clr_w, nxt;
    item_t it;
    @(posedge clk_i); #2;
    drv = st;
    set_w = '0;
    set_w[10] = drv.noack | drv.nak;
    set_w[9]  = drv.ahit & (drv.own | drv.gc);
    set_w[8]  = drv.ahit & drv.gc;
    set_w[7]  = drv.rxb;
    set_w[6]  = drv.txb;
    set_w[5]  = drv.arb;
    set_w[4]  = drv.stop & drv.slave;
    clr_w = drv.we ? (drv.wdata & 32'h0000_06F0) : '0;
    clr_w[8] = clr_w[9];
    nxt = set_w | (model & ~clr_w);
    it = '{due: cyc, is_irq: 0, mask: 32'h8, exp: {28'd0, drv.busy & ~drv.owns, 3'd0},
           exp_irq: 0, tag: {"R9 ", tag}};
    q.push_back(it);
    it = '{due: cyc + 1, is_irq: 1, mask: 0, exp: 0,
           exp_irq: |(pick(model) & drv.en), tag: {"R12 ", tag}};
    q.push_back(it);
    it = '{due: cyc + 1, is_irq: 0, mask: ~32'h8, exp: nxt, exp_irq: 0, tag: tag};
    q.push_back(it);
    model = nxt;
    st.we = 0; st.wdata = 0; st.noack = 0; st.nak = 0; st.ahit = 0; st.own = 0;
    st.gc = 0; st.rxb = 0; st.txb = 0; st.arb = 0; st.stop = 0;
  endtask

  always @(negedge clk_i) begin
    int i;
    i = 0;
    while (i < q.size()) begin
      if (q[i].due == cyc) begin
        n_chk++;
        if (q[i].is_irq) begin
          if (irq !== q[i].exp_irq) begin
            n_bad++;
            $display("FAIL %s: irq_o=%b expected %b", q[i].tag, irq, q[i].exp_irq);
          end
        end else if ((rdata & q[i].mask) !== (q[i].exp & q[i].mask)) begin
          n_bad++;
          $display("FAIL %s: rdata=%h expected %h (mask %h)", q[i].tag,
                   rdata & q[i].mask, q[i].exp & q[i].mask, q[i].mask);
        end
        q.delete(i);
      end else i++;
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    st = '{we: 0, wdata: 0, noack: 0, nak: 0, ahit: 0, own: 0, gc: 0, rxb: 0, txb: 0,
           arb: 0, stop: 0, slave: 0, busy: 0, owns: 0, en: 0};
    drv = st;
    model = '0;
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (rdata !== 32'h0 || irq !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: rdata=%h irq=%b expected 0 0", rdata, irq);
    end
    rst_ni = 1'b1;
    tick("R1 idle");

    st.noack = 1; tick("R3 master noack");
    st.we = 1; st.wdata = 32'h400; tick("R10 clear berr");
    st.nak = 1; tick("R3 slave nak");
    st.we = 1; st.wdata = 32'hFFFF_F90F; tick("R10 write zero on berr / R2 reserved");
    st.we = 1; st.wdata = 32'h400; tick("R10 clear berr again");

    st.ahit = 1; st.own = 1; tick("R4 own match");
    st.ahit = 1; tick("R4 no match");
    st.ahit = 1; st.gc = 1; tick("R5 general call");
    st.we = 1; st.wdata = 32'h100; tick("R5 write bit8 ignored");
    st.we = 1; st.wdata = 32'h200; tick("R5 clear sad clears gc");

    st.rxb = 1; tick("R6 rx full");
    st.txb = 1; tick("R6 tx empty");
    st.arb = 1; tick("R7 arb lost");
    st.stop = 1; st.slave = 0; tick("R8 stop as master");
    st.slave = 1; st.stop = 1; tick("R8 stop as slave");
    st.slave = 0; st.we = 1; st.wdata = 32'h0F0; tick("R10 clear four flags");

    st.busy = 1; st.owns = 0; tick("R9 other master");
    st.owns = 1; tick("R9 own transfer");
    st.busy = 0; st.owns = 0; tick("R9 idle");

    st.rxb = 1; st.we = 1; st.wdata = 32'h80; tick("R11 rx set vs clear");
    st.txb = 1; st.we = 1; st.wdata = 32'h40; tick("R11 tx set vs clear");
    st.ahit = 1; st.gc = 1; st.we = 1; st.wdata = 32'h200; tick("R11 gc set vs clear");

    for (int b = 0; b < 6; b++) begin
      st.en = 6'(1 << b); tick("R12 single enable");
    end
    st.en = 6'h3F; st.noack = 1; st.arb = 1; st.stop = 1; st.slave = 1; tick("R12 all set");
    tick("R12 hold");
    st.we = 1; st.wdata = 32'hFFFF_FFFF; tick("R2 R10 clear all");
    tick("R12 settle");
    st.en = 6'h00; st.rxb = 1; tick("R12 disabled");
    tick("R12 disabled hold");
    st.en = 6'h08; tick("R12 late enable");
    tick("R12 late enable hold");
    st.en = 0; st.we = 1; st.wdata = 32'hFFFF_FFFF; tick("R10 final clear");
    repeat (3) tick("drain");
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule